// File: doc/BRIEF.md
# Crosstalk Measurement Sequencer

This block controls the crosstalk measurement that runs after a headset is plugged in. On a start pulse it saves the current configuration word. It turns on a test-tone enable and measures the right output, which gives the original signal level. It then measures the left output, which gives the crosstalk level. Each result arrives over a valid/ready handshake. From the two levels the block forms an 8-bit suppression gain code, re-applies the saved configuration and pulses done. While the sequence runs, a busy output holds off jack reporting and playback start.

A cancel input aborts the run from any active step and goes straight to the restore step. Each measurement also has a programmable timeout that aborts in the same way. If the headset is flagged as high impedance when start is sampled, the block measures nothing, applies no suppression and finishes on the next cycle.

The measurement source holds `res_valid` and `res_data` stable until it sees `res_ready` high at a clock edge. A word is taken only at an edge where both are high. `res_ready` is high only while a measurement step is active, so a result offered at any other time waits.

Top module: `xtalk_seq`

## Requirements
- R1: A start pulse in the idle state with `hi_z` low enters the prepare step on the next cycle. The steps then run in a fixed order: prepare, right measure, left measure, gain compute, restore, done, idle. `busy` is high in every state except idle.
- R2: `tone_en` is high during prepare and both measure steps. `sel_right` and `res_ready` are high during right measure. `sel_left` and `res_ready` are high during left measure. At most one select is high at any time, and `res_ready` is low in every other state.
- R3: A result is taken at an edge where `res_valid` and `res_ready` are both high, and only then. The first word taken is the original level and the second is the crosstalk level. A valid word offered while `res_ready` is low is not consumed, and the sequence does not advance on it.
- R4: The gain code equals round(20·log10(2^d)), which is 6·d. Here d is the leading-one position of the original level minus that of the crosstalk level, clamped to the range 0 to 15. The leading-one position of zero is taken as 0. The code updates at the end of the compute step and is cleared to 0 when a run starts.
- R5: The `cfg_in` value is captured at the accepted start edge. `cfg_out` presents the captured value. `cfg_load` is high for exactly one cycle, in the restore step. `done` is high for exactly one cycle, the cycle after `cfg_load`.
- R6: `cancel` during prepare, either measure step or compute moves to restore on the next cycle. It sets `aborted` and leaves the gain code at 0. `cancel` in idle has no effect.
- R7: If `hi_z` is high at the accepted start edge, the next cycle is done. In that case `tone_en`, `res_ready` and `cfg_load` stay low, the gain code is 0 and `aborted` is low.
- R8: If a measure step waits `timeout_lim` cycles with no handshake, it moves to restore and sets `aborted`. A `timeout_lim` of 0 disables the timeout.
- R9: A start pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (headset inserted) |
| hi_z | input | 1 | Headset flagged high impedance, sampled with start |
| cancel | input | 1 | Abort and restore |
| timeout_lim | input | TW (16) | Cycles a measure step waits; 0 = no limit |
| cfg_in | input | CFG_W (16) | Live configuration word to save |
| cfg_out | output | CFG_W (16) | Saved configuration word |
| cfg_load | output | 1 | Apply `cfg_out` this cycle |
| tone_en | output | 1 | Test-tone enable |
| sel_right | output | 1 | Route right output to measurement |
| sel_left | output | 1 | Route left output to measurement |
| res_valid | input | 1 | Measurement word available |
| res_ready | output | 1 | Sequencer accepts a measurement word |
| res_data | input | DW (16) | Measurement level |
| gain | output | 8 | Suppression gain code |
| busy | output | 1 | Sequence in progress; hold off jack and playback reports |
| done | output | 1 | One-cycle end-of-run pulse |
| aborted | output | 1 | Last run ended by cancel or timeout |

## Verification
All outputs decode directly from the state register, so each one follows the edge that moves the state. The prepare outputs appear one edge after start is sampled. Right measure comes one edge after that, and left measure follows the edge that takes the first word. The gain code and `cfg_load` appear two edges after the second word is taken, and `done` appears one edge later. On the bypass path `done` comes one edge after start; on cancel, restore comes one edge after the cancel edge. The bench drives inputs and samples outputs one nanosecond after each rising edge. It advances one edge at a time and checks each state's outputs in the cycle where that state is due.

// File: rtl/xtalk_pkg.sv
package xtalk_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PREP, S_MEAS_R, S_MEAS_L, S_CALC, S_RESTORE, S_DONE
  } xt_state_t;

  localparam int LUT_N = 16;

  // rounded 20*log10(2^k) in integer arithmetic
  function automatic logic [7:0] db_of_octaves(input int k);
    return 8'((k * 60206 + 5000) / 10000);
  endfunction
endpackage

// File: rtl/xtalk_fsm.sv
module xtalk_fsm
  import xtalk_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          hi_z,
  input  logic          cancel,
  input  logic          hs,
  input  logic [TW-1:0] timeout_lim,
  output xt_state_t     st,
  output logic          aborted
);
  xt_state_t nxt;
  logic [TW-1:0] cnt;
  logic measuring, tmo_hit, abort_go;

  assign measuring = (st == S_MEAS_R) || (st == S_MEAS_L);
  assign tmo_hit   = (timeout_lim != '0) && (cnt == timeout_lim - 1'b1);

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE:    if (start) nxt = hi_z ? S_DONE : S_PREP;
      S_PREP:    nxt = cancel ? S_RESTORE : S_MEAS_R;
      S_MEAS_R:  if (cancel) nxt = S_RESTORE;
                 else if (hs) nxt = S_MEAS_L;
                 else if (tmo_hit) nxt = S_RESTORE;
      S_MEAS_L:  if (cancel) nxt = S_RESTORE;
                 else if (hs) nxt = S_CALC;
                 else if (tmo_hit) nxt = S_RESTORE;
      S_CALC:    nxt = S_RESTORE;
      S_RESTORE: nxt = S_DONE;
      S_DONE:    nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  assign abort_go = (nxt == S_RESTORE) && (st != S_RESTORE) &&
                    !(st == S_CALC && !cancel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      aborted <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt != st)      cnt <= '0;
      else if (measuring) cnt <= cnt + 1'b1;
      if (st == S_IDLE && start) aborted <= 1'b0;
      else if (abort_go)         aborted <= 1'b1;
    end
  end

  assert_cancel_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && (st inside {S_PREP, S_MEAS_R, S_MEAS_L, S_CALC})) |=> (st == S_RESTORE && aborted));

  assert_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MEAS_L) |-> ($past(st) == S_MEAS_R || $past(st) == S_MEAS_L));

  assert_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (measuring && !hs && !cancel && timeout_lim != '0 && cnt == timeout_lim - 1'b1)
      |=> (st == S_RESTORE));
endmodule

// File: rtl/xtalk_gain.sv
module xtalk_gain
  import xtalk_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap_orig,
  input  logic          cap_xt,
  input  logic          calc,
  input  logic [DW-1:0] data,
  output logic [7:0]    gain
);
  localparam int PW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] orig_q, xt_q;
  logic [7:0]    lut [LUT_N];
  logic [PW-1:0] p_orig, p_xt;
  int            diff;

  generate
    for (genvar k = 0; k < LUT_N; k++) begin : g_lut
      assign lut[k] = db_of_octaves(k);
    end
  endgenerate

  function automatic logic [PW-1:0] lead_pos(input logic [DW-1:0] v);
    logic [PW-1:0] p;
    p = '0;
    for (int i = 0; i < DW; i++) if (v[i]) p = PW'(i);
    return p;
  endfunction

  always_comb begin
    p_orig = lead_pos(orig_q);
    p_xt   = lead_pos(xt_q);
    diff   = int'(p_orig) - int'(p_xt);
    if (diff < 0)          diff = 0;
    if (diff > LUT_N - 1)  diff = LUT_N - 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      orig_q <= '0;
      xt_q   <= '0;
      gain   <= '0;
    end else begin
      if (cap_orig) orig_q <= data;
      if (cap_xt)   xt_q   <= data;
      if (clr)       gain <= '0;
      else if (calc) gain <= lut[diff[3:0]];
    end
  end

  assert_gain_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !calc) |=> $stable(gain));
endmodule

// File: rtl/xtalk_seq.sv
module xtalk_seq
  import xtalk_pkg::*;
#(
  parameter int DW    = 16,
  parameter int TW    = 16,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hi_z,
  input  logic             cancel,
  input  logic [TW-1:0]    timeout_lim,
  input  logic [CFG_W-1:0] cfg_in,
  output logic [CFG_W-1:0] cfg_out,
  output logic             cfg_load,
  output logic             tone_en,
  output logic             sel_right,
  output logic             sel_left,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [DW-1:0]    res_data,
  output logic [7:0]       gain,
  output logic             busy,
  output logic             done,
  output logic             aborted
);
  xt_state_t st;
  logic hs, go;

  assign go        = (st == S_IDLE) && start;
  assign sel_right = (st == S_MEAS_R);
  assign sel_left  = (st == S_MEAS_L);
  assign res_ready = sel_right || sel_left;
  assign tone_en   = (st == S_PREP) || res_ready;
  assign cfg_load  = (st == S_RESTORE);
  assign done      = (st == S_DONE);
  assign busy      = (st != S_IDLE);
  assign hs        = res_valid && res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_out <= '0;
    else if (go) cfg_out <= cfg_in;
  end

  xtalk_fsm #(.TW(TW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .hi_z(hi_z), .cancel(cancel),
    .hs(hs), .timeout_lim(timeout_lim), .st(st), .aborted(aborted)
  );

  xtalk_gain #(.DW(DW)) u_gain (
    .clk(clk), .rst_n(rst_n), .clr(go),
    .cap_orig(hs && sel_right), .cap_xt(hs && sel_left),
    .calc((st == S_CALC) && !cancel), .data(res_data), .gain(gain)
  );

  assert_sel_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_right, sel_left}));

  assert_done_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (done && !cfg_load));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy);
endmodule

// File: tb/sim_xtalk_seq.sv
module sim_xtalk_seq;
  logic clk = 0, rst_n = 0;
  logic start = 0, hi_z = 0, cancel = 0, res_valid = 0;
  logic [15:0] timeout_lim = 0, cfg_in = 0, res_data = 0;
  logic [15:0] cfg_out;
  logic cfg_load, tone_en, sel_right, sel_left, res_ready, busy, done, aborted;
  logic [7:0] gain;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  xtalk_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .hi_z(hi_z), .cancel(cancel),
    .timeout_lim(timeout_lim), .cfg_in(cfg_in), .cfg_out(cfg_out),
    .cfg_load(cfg_load), .tone_en(tone_en), .sel_right(sel_right),
    .sel_left(sel_left), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .gain(gain), .busy(busy), .done(done), .aborted(aborted)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  // outputs vector: {tone,selR,selL,ready,load,done,busy}
  function automatic logic [6:0] outs();
    return {tone_en, sel_right, sel_left, res_ready, cfg_load, done, busy};
  endfunction

  task automatic run_normal(input logic [15:0] o, input logic [15:0] x,
                            input logic [15:0] cfg, input logic [7:0] g);
    cfg_in = cfg; start = 1; tick; start = 0;
    cfg_in = ~cfg;
    chk("R1 prepare", outs(), 7'b1000001);
    res_valid = 1; res_data = o;        // offered while not ready
    tick;
    chk("R3 not consumed in prepare", outs(), 7'b1101001);
    start = 1;                          // ignored while busy
    tick; start = 0;
    chk("R2 left measure", outs(), 7'b1011001);
    res_data = x; tick; res_valid = 0;
    chk("R1 compute", outs(), 7'b0000001);
    tick;
    chk("R5 restore load", outs(), 7'b0000101);
    chk("R5 cfg value", cfg_out, cfg);
    chk("R4 gain", gain, g);
    tick;
    chk("R5 done", {outs(), aborted}, 8'b00000110);
    tick;
    chk("R9 back to idle", outs(), 7'b0000000);
  endtask

  task automatic run_cancel;
    cfg_in = 16'hC0DE; start = 1; tick; start = 0;
    tick;
    chk("R6 in right measure", sel_right, 1);
    cancel = 1; tick; cancel = 0;
    chk("R6 restore after cancel", {cfg_load, aborted, tone_en}, 3'b110);
    chk("R6 cfg", cfg_out, 16'hC0DE);
    chk("R6 gain zero", gain, 0);
    tick;
    chk("R6 done", done, 1);
    tick;
    cancel = 1; tick; cancel = 0;
    chk("R6 cancel idle no effect", {busy, done, cfg_load}, 3'b000);
  endtask

  task automatic run_timeout(input int lim);
    timeout_lim = 16'(lim);
    start = 1; tick; start = 0;
    tick;
    for (int i = 1; i < lim; i++) tick;
    chk("R8 still waiting", sel_right, 1);
    tick;
    chk("R8 timeout restore", {cfg_load, aborted}, 2'b11);
    tick; tick;
    timeout_lim = 0;
  endtask

  task automatic run_no_timeout;
    timeout_lim = 0;
    start = 1; tick; start = 0; tick;
    for (int i = 0; i < 40; i++) tick;
    chk("R8 limit zero waits", sel_right, 1);
    res_valid = 1; res_data = 16'h0100; tick;
    res_data = 16'h0010; tick; res_valid = 0;
    tick;
    chk("R4 gain after long wait", gain, 8'd24);
    tick; tick;
  endtask

  task automatic run_hiz;
    hi_z = 1; start = 1; tick; start = 0; hi_z = 0;
    chk("R7 bypass done", {outs(), aborted}, 8'b00000110);
    chk("R7 gain zero", gain, 0);
    tick;
    chk("R7 idle", busy, 0);
  endtask

  initial begin
    fork
      begin
        #2; tick;
        chk("R1 reset", {outs(), gain, aborted}, 16'h0);
        rst_n = 1; tick;
        run_normal(16'h8000, 16'h0001, 16'hA5A5, 8'd90);
        run_normal(16'h0100, 16'h0010, 16'h1234, 8'd24);
        run_normal(16'h0010, 16'h0100, 16'h0F0F, 8'd0);
        run_normal(16'hFFFF, 16'h0000, 16'h5555, 8'd90);
        run_normal(16'h0300, 16'h0200, 16'h0001, 8'd0);
        run_cancel;
        run_timeout(5);
        run_no_timeout;
        run_hiz;
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule